// File: doc/BRIEF.md
# Rotated Byte Constant Codec

This block decides whether a 32-bit constant can be produced by rotating an 8-bit payload right by an even amount inside a 32-bit word. For each accepted word it returns a success flag, the payload and a 4-bit rotate code. The rotation applied is twice the code, so the legal rotations are 0, 2, … 30. All sixteen rotations are examined side by side, and a priority pick keeps the smallest code that works. When no code works, the payload and the code come out as zero.

Constants reach the encoder on a valid/ready stream. One output register holds each result until the consumer takes it. The rules for back-pressure are these. `in_ready` is high whenever the register is empty or is being drained in the same cycle. A result stays frozen while `out_valid` is high and `out_ready` is low. Results leave in the order their inputs were accepted, one cycle after acceptance at the earliest.

A separate decoder port expands any payload and code back into the 32-bit word. It is purely combinational, so round trips can be checked against it.

Top module: `rot_imm_codec`

## Requirements
- R1: Every input from 0x00000000 to 0x000000FF is reported with out_ok=1, out_rot=0 and out_imm8 equal to the input.
- R2: out_ok is 1 exactly when the input equals the 8-bit out_imm8 rotated right by 2*out_rot bits (out_rot from 0 to 15) within 32 bits.
- R3: Constants whose set bits wrap across the bit 31 / bit 0 boundary are accepted, e.g. 0xF000000F gives imm8 0xFF, rot 2, and 0x80000000 gives imm8 0x02, rot 1.
- R4: Constants whose set bits span more than 8 bits, or that sit on an odd alignment, are rejected, e.g. 0x00000123, 0x000001FE and 0xFFFFFFFF give out_ok=0.
- R5: When several codes reproduce the input, the smallest out_rot is reported (0x00000040 gives rot 0, imm8 0x40; 0x000AD000 gives rot 10, imm8 0xAD).
- R6: When out_ok is 0, out_imm8 and out_rot are both 0.
- R7: dec_value equals dec_imm8 zero-extended to 32 bits and rotated right by 2*dec_rot bits, in the same cycle.
- R8: For every accepted constant, feeding out_imm8 and out_rot to the decoder port reproduces the input.
- R9: in_ready = !out_valid || out_ready, and while out_valid=1 and out_ready=0 the result holds and stays valid on the next cycle.
- R10: After reset out_valid is 0. A word accepted at a clock edge is presented with out_valid=1 after that edge, and results come out in acceptance order, one per accepted word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Constant offered |
| in_ready | output | 1 | Encoder can take a constant |
| in_value | input | 32 | Constant to encode |
| out_valid | output | 1 | Result held |
| out_ready | input | 1 | Consumer takes result |
| out_ok | output | 1 | Constant is encodable |
| out_imm8 | output | 8 | Payload byte |
| out_rot | output | 4 | Rotate code (right rotate by twice this) |
| dec_imm8 | input | 8 | Payload byte to expand |
| dec_rot | input | 4 | Rotate code to expand |
| dec_value | output | 32 | Expanded 32-bit word |

## Verification
Two events can fall in the same cycle. The held result can drain while a new constant is loaded, and the frozen result can be held while the producer is refused. The bench provokes both by streaming back-to-back constants while it toggles out_ready in an uneven pattern. A scoreboard computes each expected result by brute-force search over all payload and rotation pairs. Any duplicate, loss or change in a held result shows up as a mismatch at the monitor. Each popped result is also pushed through the decoder port, which judges the round trip.

// File: rtl/rot_imm_pkg.sv
package rot_imm_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned PAY_W  = 8;
  localparam int unsigned CODE_W = 4;
endpackage

// File: rtl/rie_scan.sv
module rie_scan #(
  parameter int unsigned WORD_W = rot_imm_pkg::WORD_W,
  parameter int unsigned PAY_W  = rot_imm_pkg::PAY_W,
  parameter int unsigned CODE_W = rot_imm_pkg::CODE_W,
  localparam int unsigned N_CODE = 1 << CODE_W,
  localparam int unsigned STEP   = WORD_W / N_CODE
) (
  input  logic [WORD_W-1:0]             word_i,
  output logic [N_CODE-1:0]             hit_o,
  output logic [N_CODE-1:0][PAY_W-1:0]  pay_o
);
  // Undoing a right rotation by k*STEP is a left rotation by the same amount;
  // the code fits when everything above the payload is zero afterwards.
  for (genvar k = 0; k < N_CODE; k++) begin : g_code
    localparam int unsigned SH = k * STEP;
    logic [WORD_W-1:0] back;
    if (SH == 0) begin : g_plain
      assign back = word_i;
    end else begin : g_rot
      assign back = (word_i << SH) | (word_i >> (WORD_W - SH));
    end
    assign hit_o[k] = ~|back[WORD_W-1:PAY_W];
    assign pay_o[k] = back[PAY_W-1:0];
  end
endmodule

// File: rtl/rie_pick.sv
module rie_pick #(
  parameter int unsigned PAY_W  = rot_imm_pkg::PAY_W,
  parameter int unsigned CODE_W = rot_imm_pkg::CODE_W,
  localparam int unsigned N_CODE = 1 << CODE_W
) (
  input  logic [N_CODE-1:0]             hit_i,
  input  logic [N_CODE-1:0][PAY_W-1:0]  pay_i,
  output logic                          ok_o,
  output logic [N_CODE-1:0]             grant_o,
  output logic [PAY_W-1:0]              pay_o,
  output logic [CODE_W-1:0]             code_o
);
  always_comb begin
    ok_o    = 1'b0;
    grant_o = '0;
    pay_o   = '0;
    code_o  = '0;
    for (int k = 0; k < int'(N_CODE); k++) begin
      if (hit_i[k] && !ok_o) begin
        ok_o       = 1'b1;
        grant_o[k] = 1'b1;
        pay_o      = pay_i[k];
        code_o     = CODE_W'(k);
      end
    end
  end
endmodule

// File: rtl/rie_expand.sv
module rie_expand #(
  parameter int unsigned WORD_W = rot_imm_pkg::WORD_W,
  parameter int unsigned PAY_W  = rot_imm_pkg::PAY_W,
  parameter int unsigned CODE_W = rot_imm_pkg::CODE_W,
  localparam int unsigned N_CODE = 1 << CODE_W,
  localparam int unsigned STEP   = WORD_W / N_CODE
) (
  input  logic [PAY_W-1:0]  pay_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [WORD_W-1:0] word_o
);
  logic [WORD_W-1:0]              base;
  logic [N_CODE-1:0][WORD_W-1:0]  turned;

  assign base = {{(WORD_W-PAY_W){1'b0}}, pay_i};

  for (genvar k = 0; k < N_CODE; k++) begin : g_code
    localparam int unsigned SH = k * STEP;
    if (SH == 0) begin : g_plain
      assign turned[k] = base;
    end else begin : g_rot
      assign turned[k] = (base >> SH) | (base << (WORD_W - SH));
    end
  end

  assign word_o = turned[code_i];
endmodule

// File: rtl/rie_hold.sv
module rie_hold #(
  parameter int unsigned PAY_W  = rot_imm_pkg::PAY_W,
  parameter int unsigned CODE_W = rot_imm_pkg::CODE_W,
  localparam int unsigned RES_W = 1 + PAY_W + CODE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_valid_i,
  output logic             load_ready_o,
  input  logic [RES_W-1:0] load_data_i,
  output logic             hold_valid_o,
  input  logic             hold_ready_i,
  output logic [RES_W-1:0] hold_data_o
);
  assign load_ready_o = !hold_valid_o || hold_ready_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_valid_o <= 1'b0;
      hold_data_o  <= '0;
    end else if (load_ready_o) begin
      hold_valid_o <= load_valid_i;
      if (load_valid_i) hold_data_o <= load_data_i;
    end
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    hold_valid_o && !hold_ready_i |=> hold_valid_o && $stable(hold_data_o)); // R9
  AST_LOAD_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
    load_valid_i && load_ready_o |=> hold_valid_o); // R10
  AST_DRAIN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    hold_valid_o && hold_ready_i && !load_valid_i |=> !hold_valid_o); // R10
endmodule

// File: rtl/rot_imm_codec.sv
module rot_imm_codec #(
  parameter int unsigned WORD_W = rot_imm_pkg::WORD_W,
  parameter int unsigned PAY_W  = rot_imm_pkg::PAY_W,
  parameter int unsigned CODE_W = rot_imm_pkg::CODE_W,
  localparam int unsigned N_CODE = 1 << CODE_W,
  localparam int unsigned STEP   = WORD_W / N_CODE,
  localparam int unsigned RES_W  = 1 + PAY_W + CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_value,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_ok,
  output logic [PAY_W-1:0]  out_imm8,
  output logic [CODE_W-1:0] out_rot,
  input  logic [PAY_W-1:0]  dec_imm8,
  input  logic [CODE_W-1:0] dec_rot,
  output logic [WORD_W-1:0] dec_value
);
  logic [N_CODE-1:0]            hit;
  logic [N_CODE-1:0][PAY_W-1:0] pay;
  logic [N_CODE-1:0]            grant;
  logic                         enc_ok;
  logic [PAY_W-1:0]             enc_pay;
  logic [CODE_W-1:0]            enc_code;
  logic [RES_W-1:0]             held;

  rie_scan #(.WORD_W(WORD_W), .PAY_W(PAY_W), .CODE_W(CODE_W)) u_scan (
    .word_i(in_value), .hit_o(hit), .pay_o(pay));

  rie_pick #(.PAY_W(PAY_W), .CODE_W(CODE_W)) u_pick (
    .hit_i(hit), .pay_i(pay), .ok_o(enc_ok), .grant_o(grant),
    .pay_o(enc_pay), .code_o(enc_code));

  rie_hold #(.PAY_W(PAY_W), .CODE_W(CODE_W)) u_hold (
    .clk(clk), .rst_n(rst_n),
    .load_valid_i(in_valid), .load_ready_o(in_ready),
    .load_data_i({enc_ok, enc_pay, enc_code}),
    .hold_valid_o(out_valid), .hold_ready_i(out_ready), .hold_data_o(held));

  assign {out_ok, out_imm8, out_rot} = held;

  rie_expand #(.WORD_W(WORD_W), .PAY_W(PAY_W), .CODE_W(CODE_W)) u_expand (
    .pay_i(dec_imm8), .code_i(dec_rot), .word_o(dec_value));

  function automatic logic [WORD_W-1:0] spin(input logic [PAY_W-1:0] p,
                                             input logic [CODE_W-1:0] c);
    logic [WORD_W-1:0] w;
    w = {{(WORD_W-PAY_W){1'b0}}, p};
    for (int i = 0; i < int'(c) * int'(STEP); i++) w = {w[0], w[WORD_W-1:1]};
    return w;
  endfunction

  AST_SMALL_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && (in_value >> PAY_W) == '0 |-> enc_ok && enc_code == '0); // R1
  AST_ROUND_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && enc_ok |-> spin(enc_pay, enc_code) == in_value); // R8
  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && (enc_ok == |grant)); // R5
  AST_ZERO_WHEN_BAD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ok |-> out_imm8 == '0 && out_rot == '0); // R6
endmodule

// File: tb/rot_imm_codec_test.sv
`timescale 1ns/1ps
module rot_imm_codec_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_value = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic        out_ok;
  logic [7:0]  out_imm8;
  logic [3:0]  out_rot;
  logic [7:0]  dec_imm8 = '0;
  logic [3:0]  dec_rot = '0;
  logic [31:0] dec_value;

  int checks = 0;
  int errors = 0;
  int bp_mode = 0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] value;
    logic        ok;
    logic [7:0]  imm;
    logic [3:0]  rot;
    string       tag;
  } item_t;
  item_t sb[$];

  rot_imm_codec uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_value(in_value), .out_valid(out_valid), .out_ready(out_ready),
    .out_ok(out_ok), .out_imm8(out_imm8), .out_rot(out_rot),
    .dec_imm8(dec_imm8), .dec_rot(dec_rot), .dec_value(dec_value));

  always #2 clk = ~clk;

  function automatic logic [31:0] ref_ror(input logic [31:0] w, input int n);
    for (int i = 0; i < n; i++) w = {w[0], w[31:1]};
    return w;
  endfunction

  // Brute force: every payload under every code, smallest code wins.
  function automatic item_t model(input logic [31:0] v, input string tag);
    item_t it;
    it.value = v; it.ok = 1'b0; it.imm = '0; it.rot = '0; it.tag = tag;
    for (int r = 0; r < 16; r++) begin
      for (int p = 0; p < 256; p++) begin
        if (!it.ok && ref_ror(32'(p), 2 * r) == v) begin
          it.ok = 1'b1; it.imm = 8'(p); it.rot = 4'(r);
        end
      end
    end
    return it;
  endfunction

  task automatic check(input bit good, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!good) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic send(input logic [31:0] v, input string tag);
    sb.push_back(model(v, tag));
    @(negedge clk);
    in_valid = 1'b1;
    in_value = v;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Back-pressure pattern generator
  int bp_cnt = 0;
  initial begin
    forever begin
      @(negedge clk);
      bp_cnt++;
      case (bp_mode)
        1: out_ready = (bp_cnt % 3) != 0;
        2: out_ready = (bp_cnt % 5) == 0;
        default: out_ready = 1'b1;
      endcase
    end
  end

  // Monitor / scoreboard
  logic        stall_prev = 1'b0;
  logic [12:0] stall_snap = '0;
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rst_n) begin
        if (stall_prev)
          check(out_valid === 1'b1 && {out_ok, out_imm8, out_rot} === stall_snap,
                "R9", "held result changed", {19'd0, out_ok, out_imm8, out_rot},
                {19'd0, stall_snap});
        stall_prev = out_valid && !out_ready;
        stall_snap = {out_ok, out_imm8, out_rot};
        if (out_valid && out_ready) begin
          if (sb.size() == 0) begin
            check(1'b0, "R10", "result with nothing pending", {19'd0, out_ok, out_imm8, out_rot}, '0);
          end else begin
            item_t e;
            e = sb.pop_front();
            check(out_ok === e.ok, e.tag, "ok flag", {31'd0, out_ok}, {31'd0, e.ok});
            check(out_imm8 === e.imm && out_rot === e.rot, e.tag, "imm8/rot",
                  {20'd0, out_imm8, out_rot}, {20'd0, e.imm, e.rot});
            if (out_ok === 1'b1) begin
              dec_imm8 = out_imm8;
              dec_rot  = out_rot;
              #0.5;
              check(dec_value === e.value, "R8", "round trip", dec_value, e.value);
            end
          end
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  logic [31:0] lfsr = 32'h1ACE_B00C;
  function automatic logic [31:0] step(input logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  initial begin
    // Reset state (R10)
    repeat (3) @(negedge clk);
    #1;
    check(out_valid === 1'b0, "R10", "out_valid in reset", {31'd0, out_valid}, 0);
    check(in_ready === 1'b1, "R9", "in_ready in reset", {31'd0, in_ready}, 1);

    // Decoder port alone (R7)
    for (int r = 0; r < 16; r++) begin
      dec_imm8 = 8'hA5 ^ 8'(r * 17);
      dec_rot  = 4'(r);
      #1;
      check(dec_value === ref_ror({24'd0, dec_imm8}, 2 * r), "R7", "decoder value",
            dec_value, ref_ror({24'd0, dec_imm8}, 2 * r));
    end

    @(negedge clk);
    rst_n = 1'b1;

    // One-cycle latency (R10)
    sb.push_back(model(32'h55, "R1"));
    @(negedge clk);
    in_valid = 1'b1; in_value = 32'h55;
    @(negedge clk);
    in_valid = 1'b0;
    #1.5;
    check(out_valid === 1'b1, "R10", "valid one cycle after accept", {31'd0, out_valid}, 1);
    repeat (2) @(negedge clk);

    // Small values (R1)
    for (int v = 0; v < 256; v += 15) send(32'(v), "R1");
    send(32'hFF, "R1");
    // Wrapping (R3)
    send(32'hF000000F, "R3");
    send(32'h80000000, "R3");
    send(32'hC000003F, "R3");
    // Rejections (R4, R6)
    send(32'h00000123, "R4");
    send(32'h000001FE, "R4");
    send(32'hFFFFFFFF, "R4");
    send(32'h00010001, "R6");
    // Smallest code (R5)
    send(32'h00000040, "R5");
    send(32'h000AD000, "R5");
    send(32'h000003FC, "R5");
    send(32'h00000104, "R5");

    // Back-pressure with streaming (R9, R2)
    bp_mode = 1;
    for (int i = 0; i < 40; i++) begin
      lfsr = step(lfsr);
      if (i % 2 == 0) send(ref_ror({24'd0, lfsr[7:0]}, 2 * int'(lfsr[11:8])), "R2");
      else            send(lfsr, "R2");
    end
    bp_mode = 2;
    for (int i = 0; i < 20; i++) begin
      lfsr = step(lfsr);
      send(ref_ror({24'd0, lfsr[7:0]}, int'(lfsr[12:8])), "R2");
    end
    idle();
    bp_mode = 0;
    repeat (20) @(negedge clk);
    check(sb.size() == 0, "R10", "pending results drained", 32'(sb.size()), 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule